// File: doc/BRIEF.md
# Addressed Discrete I/O Bit Unit

This unit serves a small 4-bit controller. It executes three single-bit commands: set, clear and test. Each command acts on one bit, and the low nibble of the RAM address register picks that bit. In the normal mode, nibble values 0 to 9 select bits of a latched output port. Values 10 and 11 select one of two interrupt flip-flops, with the index inverted: 10 addresses flip-flop 1 and 11 addresses flip-flop 0. Values 12 to 15 are rejected. A command is also rejected when address bit 6 is high.

A test command does not change state. It reports a skip request to the sequencer when the chosen bit reads as zero. A pin reads as the latch ORed with the live input pins, then ANDed with the output mask. A rejected command leaves all state untouched and raises an invalid-access pulse instead.

A build-time legacy mode is also available. In that mode the unit takes a command only while address bits 5:4 equal 3, or in the cycle right after they left 3. Address bit 6 plays no part in that mode, and every index at or above the pin count is rejected.

Top module: `io_bit_unit`

## Requirements
- R1: A synchronous reset clears the output latch and both interrupt flip-flops, and holds skip_req and bad_access low.
- R2: In normal mode, a set command with nibble i < 10 and address bit 6 low loads latch := (latch | (1 << i)) & out_mask, seen on port_out the cycle after the strobe.
- R3: In normal mode, a clear command with nibble i < 10 and address bit 6 low clears latch bit i; the other bits are kept and the mask is not applied.
- R4: In normal mode, nibble 10 addresses irq_ff[1] and nibble 11 addresses irq_ff[0]; set writes 1 and clear writes 0 to that flip-flop.
- R5: A test command on nibble i < 10 pulses skip_req in the next cycle exactly when bit i of ((latch | pin_in) & out_mask) is 0.
- R6: A test command on nibble 10 or 11 pulses skip_req in the next cycle exactly when the selected flip-flop (same mapping as R4) is 0.
- R7: In normal mode, any command with ram_addr[6] = 1 changes neither port_out nor irq_ff, gives no skip, and pulses bad_access in the next cycle.
- R8: In normal mode, any command with nibble 12 to 15 changes no state, gives no skip, and pulses bad_access in the next cycle.
- R9: skip_req and bad_access are one-cycle pulses. Both are low in any cycle that does not follow a strobe, and skip_req follows only a test strobe.
- R10: In legacy mode, a command is taken only if ram_addr[5:4] = 3 now or held 3 in the previous cycle. Outside that window the command has no effect and raises neither skip_req nor bad_access.
- R11: In legacy mode, nibbles at or above NUM_PINS pulse bad_access and change nothing. Address bit 6 is ignored.
- R12: If several strobes arrive in one cycle, only one command runs, chosen in the order set, then clear, then test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_stb | input | 1 | Set-bit command strobe |
| clr_stb | input | 1 | Clear-bit command strobe |
| tst_stb | input | 1 | Test-bit command strobe |
| ram_addr | input | 7 | Current RAM address register |
| pin_in | input | NUM_PINS | Live levels of the port pins |
| out_mask | input | NUM_PINS | Mask applied on set and on test reads |
| port_out | output | NUM_PINS | Output latch, driven continuously |
| irq_ff | output | 2 | The two interrupt flip-flops |
| skip_req | output | 1 | Skip request pulse for the sequencer |
| bad_access | output | 1 | Invalid-access pulse |

## Verification
A latch update from a set and the read done by a test can meet in back-to-back cycles. The sweep issues a set, then a test on the same nibble, then a clear, then a test again, so every test reads a value written one edge earlier. The bench predicts skip_req from the value its own model holds after the write. This shows whether the test sees the updated latch or the stale one. The sweep repeats under several mask and pin patterns, so the OR with the live pins and the masking of a set are judged separately for each pin.

// File: rtl/io_bit_pkg.sv
package io_bit_pkg;

  localparam int ADDR_W    = 7;
  localparam int IDX_W     = 4;
  localparam int NUM_FLAGS = 2;
  localparam int FLAG_BASE = 10;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TST  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    TGT_IDLE = 2'd0,
    TGT_PIN  = 2'd1,
    TGT_FLAG = 2'd2,
    TGT_BAD  = 2'd3
  } tgt_e;

  // Strobe priority: set over clear over test.
  function automatic op_e pick_op(input logic s, input logic c, input logic t);
    if (s)      return OP_SET;
    else if (c) return OP_CLR;
    else if (t) return OP_TST;
    else        return OP_NONE;
  endfunction

  // Flip-flop number is the inverted low index bit.
  function automatic logic flag_of(input logic [IDX_W-1:0] idx);
    return ~idx[0];
  endfunction

  // Legacy window: upper field at 3 now, or at 3 one cycle ago.
  function automatic logic in_window(input logic [1:0] now_hi, input logic [1:0] old_hi);
    return (now_hi == 2'b11) || (old_hi == 2'b11);
  endfunction

  function automatic tgt_e std_target(input logic b6, input logic [IDX_W-1:0] idx,
                                      input int npins);
    if (b6)                                        return TGT_BAD;
    if (int'(idx) < npins)                         return TGT_PIN;
    if (int'(idx) >= FLAG_BASE &&
        int'(idx) <  FLAG_BASE + NUM_FLAGS)        return TGT_FLAG;
    return TGT_BAD;
  endfunction

  function automatic tgt_e leg_target(input logic win, input logic [IDX_W-1:0] idx,
                                      input int npins);
    if (!win)              return TGT_IDLE;
    if (int'(idx) < npins) return TGT_PIN;
    return TGT_BAD;
  endfunction

endpackage

// File: rtl/io_bit_decode.sv
module io_bit_decode
  import io_bit_pkg::*;
#(
  parameter int NUM_PINS = 10,
  parameter bit LEGACY   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ram_addr,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  idx
);

  assign idx = ram_addr[IDX_W-1:0];

  generate
    if (LEGACY) begin : g_legacy
      logic [1:0] hi_q;
      logic       unused_leg;
      always_ff @(posedge clk) begin
        if (rst) hi_q <= 2'b00;
        else     hi_q <= ram_addr[5:4];
      end
      assign tgt        = leg_target(in_window(ram_addr[5:4], hi_q), idx, NUM_PINS);
      assign unused_leg = ram_addr[6];
    end else begin : g_normal
      logic unused_std;
      assign tgt        = std_target(ram_addr[6], idx, NUM_PINS);
      assign unused_std = ^{clk, rst, ram_addr[5:4]};
    end
  endgenerate

endmodule

// File: rtl/io_bit_latch.sv
module io_bit_latch
  import io_bit_pkg::*;
#(
  parameter int NUM_PINS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  op_e                 op,
  input  tgt_e                tgt,
  input  logic [NUM_PINS-1:0] sel,
  input  logic [NUM_PINS-1:0] mask,
  output logic [NUM_PINS-1:0] lat
);

  logic [NUM_PINS-1:0] nxt;

  always_comb begin
    nxt = lat;
    if (tgt == TGT_PIN) begin
      case (op)
        OP_SET:  nxt = (lat | sel) & mask;
        OP_CLR:  nxt = lat & ~sel;
        default: nxt = lat;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lat <= '0;
    else     lat <= nxt;
  end

endmodule

// File: rtl/io_bit_flags.sv
module io_bit_flags
  import io_bit_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  op_e                  op,
  input  tgt_e                 tgt,
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_FLAGS-1:0] ff
);

  logic pick;
  assign pick = flag_of(idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      ff <= '0;
    end else if (tgt == TGT_FLAG) begin
      if (op == OP_SET)      ff[pick] <= 1'b1;
      else if (op == OP_CLR) ff[pick] <= 1'b0;
    end
  end

endmodule

// File: rtl/io_bit_resp.sv
module io_bit_resp
  import io_bit_pkg::*;
#(
  parameter int NUM_PINS = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  op_e                  op,
  input  tgt_e                 tgt,
  input  logic [IDX_W-1:0]     idx,
  input  logic [NUM_PINS-1:0]  sel,
  input  logic [NUM_PINS-1:0]  lat,
  input  logic [NUM_PINS-1:0]  pins,
  input  logic [NUM_PINS-1:0]  mask,
  input  logic [NUM_FLAGS-1:0] ff,
  output logic                 skip_q,
  output logic                 bad_q
);

  logic [NUM_PINS-1:0] view;
  logic                pin_lvl;
  logic                flag_lvl;
  logic                skip_d;

  assign view     = (lat | pins) & mask;
  assign pin_lvl  = |(view & sel);
  assign flag_lvl = ff[flag_of(idx)];

  always_comb begin
    skip_d = 1'b0;
    if (op == OP_TST) begin
      if (tgt == TGT_PIN)       skip_d = ~pin_lvl;
      else if (tgt == TGT_FLAG) skip_d = ~flag_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      skip_q <= skip_d;
      bad_q  <= (op != OP_NONE) && (tgt == TGT_BAD);
    end
  end

endmodule

// File: rtl/io_bit_unit.sv
module io_bit_unit
  import io_bit_pkg::*;
#(
  parameter int NUM_PINS = 10,
  parameter bit LEGACY   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_stb,
  input  logic                 clr_stb,
  input  logic                 tst_stb,
  input  logic [ADDR_W-1:0]    ram_addr,
  input  logic [NUM_PINS-1:0]  pin_in,
  input  logic [NUM_PINS-1:0]  out_mask,
  output logic [NUM_PINS-1:0]  port_out,
  output logic [NUM_FLAGS-1:0] irq_ff,
  output logic                 skip_req,
  output logic                 bad_access
);

  op_e                 cur_op;
  tgt_e                cur_tgt;
  logic [IDX_W-1:0]    cur_idx;
  logic [NUM_PINS-1:0] pin_sel;

  // Named events for the checker
  logic ev_set_pin, ev_clr_pin, ev_set_flag, ev_clr_flag;

  assign cur_op = pick_op(set_stb, clr_stb, tst_stb);

  io_bit_decode #(.NUM_PINS(NUM_PINS), .LEGACY(LEGACY)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .ram_addr (ram_addr),
    .tgt      (cur_tgt),
    .idx      (cur_idx)
  );

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_sel
      assign pin_sel[i] = (cur_idx == IDX_W'(i));
    end
  endgenerate

  assign ev_set_pin  = (cur_op == OP_SET) && (cur_tgt == TGT_PIN);
  assign ev_clr_pin  = (cur_op == OP_CLR) && (cur_tgt == TGT_PIN);
  assign ev_set_flag = (cur_op == OP_SET) && (cur_tgt == TGT_FLAG);
  assign ev_clr_flag = (cur_op == OP_CLR) && (cur_tgt == TGT_FLAG);

  io_bit_latch #(.NUM_PINS(NUM_PINS)) u_lat (
    .clk  (clk),
    .rst  (rst),
    .op   (cur_op),
    .tgt  (cur_tgt),
    .sel  (pin_sel),
    .mask (out_mask),
    .lat  (port_out)
  );

  io_bit_flags u_flg (
    .clk (clk),
    .rst (rst),
    .op  (cur_op),
    .tgt (cur_tgt),
    .idx (cur_idx),
    .ff  (irq_ff)
  );

  io_bit_resp #(.NUM_PINS(NUM_PINS)) u_rsp (
    .clk    (clk),
    .rst    (rst),
    .op     (cur_op),
    .tgt    (cur_tgt),
    .idx    (cur_idx),
    .sel    (pin_sel),
    .lat    (port_out),
    .pins   (pin_in),
    .mask   (out_mask),
    .ff     (irq_ff),
    .skip_q (skip_req),
    .bad_q  (bad_access)
  );

endmodule

// File: rtl/io_bit_unit_chk.sv
module io_bit_unit_chk
  import io_bit_pkg::*;
#(
  parameter int NUM_PINS = 10,
  parameter bit LEGACY   = 1'b0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 set_stb,
  input logic                 clr_stb,
  input logic                 tst_stb,
  input logic [ADDR_W-1:0]    ram_addr,
  input logic [NUM_PINS-1:0]  out_mask,
  input logic [NUM_PINS-1:0]  port_out,
  input logic [NUM_FLAGS-1:0] irq_ff,
  input logic                 skip_req,
  input logic                 bad_access,
  input logic [NUM_PINS-1:0]  pin_sel,
  input logic                 ev_set_pin,
  input logic                 ev_clr_pin,
  input logic                 ev_set_flag,
  input logic                 ev_clr_flag
);

  logic any_stb;
  assign any_stb = set_stb | clr_stb | tst_stb;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (port_out == '0 && irq_ff == '0 && !skip_req && !bad_access));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !any_stb |=> (!skip_req && !bad_access));

  // R9
  skip_after_test_chk: assert property (@(posedge clk) disable iff (rst)
    skip_req |-> $past(tst_stb));

  // R7
  high_addr_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (!LEGACY && any_stb && ram_addr[6]) |=>
      (bad_access && !skip_req && $stable(port_out) && $stable(irq_ff)));

  // R8
  high_index_chk: assert property (@(posedge clk) disable iff (rst)
    (!LEGACY && any_stb && ram_addr[3:2] == 2'b11) |=>
      (bad_access && !skip_req && $stable(port_out) && $stable(irq_ff)));

  // R2
  set_pin_chk: assert property (@(posedge clk) disable iff (rst)
    ev_set_pin |=> ((port_out & $past(pin_sel)) == ($past(out_mask) & $past(pin_sel))));

  // R3
  clr_pin_chk: assert property (@(posedge clk) disable iff (rst)
    ev_clr_pin |=> ((port_out & $past(pin_sel)) == '0));

  // R4
  set_flag_ten_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_set_flag && !ram_addr[0]) |=> irq_ff[1]);

  // R4
  clr_flag_eleven_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_clr_flag && ram_addr[0]) |=> !irq_ff[0]);

  logic unused_chk;
  assign unused_chk = ^{ram_addr[5:4], ram_addr[1]};

endmodule

bind io_bit_unit io_bit_unit_chk #(.NUM_PINS(NUM_PINS), .LEGACY(LEGACY)) u_chk (.*);

// File: tb/io_bit_unit_bench.sv
module io_bit_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 10;
  localparam int LNP        = 8;
  localparam int WATCHDOG   = 100000;

  logic          clk = 1'b0;
  logic          rst;
  logic          set_stb, clr_stb, tst_stb;
  logic [6:0]    ram_addr;
  logic [NP-1:0] pin_in, out_mask, port_out;
  logic [1:0]    irq_ff;
  logic          skip_req, bad_access;

  logic           l_set, l_clr, l_tst;
  logic [6:0]     l_addr;
  logic [LNP-1:0] l_pins, l_mask, l_out;
  logic [1:0]     l_irq;
  logic           l_skip, l_bad;

  int vectors     = 0;
  int miscompares = 0;
  logic [NP-1:0] m_lat;
  logic [1:0]    m_ff;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_bit_unit #(.NUM_PINS(NP), .LEGACY(1'b0)) u_io_bit_unit (
    .clk(clk), .rst(rst), .set_stb(set_stb), .clr_stb(clr_stb), .tst_stb(tst_stb),
    .ram_addr(ram_addr), .pin_in(pin_in), .out_mask(out_mask), .port_out(port_out),
    .irq_ff(irq_ff), .skip_req(skip_req), .bad_access(bad_access)
  );

  io_bit_unit #(.NUM_PINS(LNP), .LEGACY(1'b1)) u_io_bit_unit_leg (
    .clk(clk), .rst(rst), .set_stb(l_set), .clr_stb(l_clr), .tst_stb(l_tst),
    .ram_addr(l_addr), .pin_in(l_pins), .out_mask(l_mask), .port_out(l_out),
    .irq_ff(l_irq), .skip_req(l_skip), .bad_access(l_bad)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // op: 1 set, 2 clear, 3 test
  task automatic run_cmd(input int op, input logic [6:0] a);
    int    idx;
    int    f;
    logic  e_skip, e_bad;
    string req;
    idx = int'(a[3:0]);
    e_skip = 1'b0;
    e_bad  = 1'b0;
    if (a[6]) begin
      e_bad = 1'b1; req = "R7";
    end else if (idx < 10) begin
      if (op == 1) begin
        m_lat = (m_lat | NP'(1 << idx)) & out_mask; req = "R2";
      end else if (op == 2) begin
        m_lat = m_lat & ~NP'(1 << idx); req = "R3";
      end else begin
        e_skip = ((((m_lat | pin_in) & out_mask) >> idx) & NP'(1)) == '0; req = "R5";
      end
    end else if (idx < 12) begin
      f = 11 - idx;
      if (op == 1)      begin m_ff[f] = 1'b1; req = "R4"; end
      else if (op == 2) begin m_ff[f] = 1'b0; req = "R4"; end
      else              begin e_skip = !m_ff[f]; req = "R6"; end
    end else begin
      e_bad = 1'b1; req = "R8";
    end
    set_stb  = (op == 1);
    clr_stb  = (op == 2);
    tst_stb  = (op == 3);
    ram_addr = a;
    @(posedge clk);
    @(negedge clk);
    set_stb = 1'b0; clr_stb = 1'b0; tst_stb = 1'b0;
    chk(req, 32'(port_out), 32'(m_lat));
    chk(req, 32'(irq_ff), 32'(m_ff));
    chk(req, 32'(skip_req), 32'(e_skip));
    chk(req, 32'(bad_access), 32'(e_bad));
  endtask

  task automatic leg_cmd(input int op, input logic [6:0] a, input logic [LNP-1:0] e_lat,
                         input logic e_skip, input logic e_bad, input string req);
    l_set  = (op == 1);
    l_clr  = (op == 2);
    l_tst  = (op == 3);
    l_addr = a;
    @(posedge clk);
    @(negedge clk);
    l_set = 1'b0; l_clr = 1'b0; l_tst = 1'b0;
    chk(req, 32'(l_out), 32'(e_lat));
    chk(req, 32'(l_irq), 32'd0);
    chk(req, 32'(l_skip), 32'(e_skip));
    chk(req, 32'(l_bad), 32'(e_bad));
  endtask

  initial begin
    for (int cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [NP-1:0] masks [3];
    logic [NP-1:0] pinsv [3];
    int            ops   [4];
    masks = '{10'h3FF, 10'h2AA, 10'h155};
    pinsv = '{10'h000, 10'h0F0, 10'h3FF};
    ops   = '{1, 3, 2, 3};

    rst = 1'b1;
    set_stb = 1'b1; clr_stb = 1'b0; tst_stb = 1'b0;
    ram_addr = 7'h01; pin_in = '0; out_mask = '1;
    l_set = 1'b1; l_clr = 1'b0; l_tst = 1'b0;
    l_addr = 7'h00; l_pins = '0; l_mask = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state cleared while reset dominates the strobes
    chk("R1", 32'(port_out), 32'd0);
    chk("R1", 32'(irq_ff), 32'd0);
    chk("R1", 32'({skip_req, bad_access}), 32'd0);
    chk("R1", 32'(l_out), 32'd0);
    set_stb = 1'b0; l_set = 1'b0;
    rst = 1'b0;
    m_lat = '0;
    m_ff  = '0;

    // Sweep: every nibble, bit 6 low and high, set/test/clear/test
    for (int p = 0; p < 3; p++) begin
      out_mask = masks[p];
      pin_in   = pinsv[p];
      for (int b6 = 0; b6 < 2; b6++) begin
        for (int i = 0; i < 16; i++) begin
          for (int k = 0; k < 4; k++) begin
            run_cmd(ops[k], {b6[0], 2'b00, i[3:0]});
          end
        end
      end
      // R9: idle cycle after a command, pulses gone and state held
      ram_addr = 7'h0A;
      @(posedge clk);
      @(negedge clk);
      chk("R9", 32'({skip_req, bad_access}), 32'd0);
      chk("R9", 32'(port_out), 32'(m_lat));
    end

    // Leave state set so the priority cases have something to act on
    out_mask = '1; pin_in = '0;
    run_cmd(1, 7'h07);
    run_cmd(1, 7'h0B);

    // R12: set and clear together on nibble 3 -> set wins
    set_stb = 1'b1; clr_stb = 1'b1; ram_addr = 7'h03;
    @(posedge clk); @(negedge clk);
    set_stb = 1'b0; clr_stb = 1'b0;
    m_lat[3] = 1'b1;
    chk("R12", 32'(port_out), 32'(m_lat));
    // R12: clear and test together on nibble 3 -> clear only, no skip
    clr_stb = 1'b1; tst_stb = 1'b1; ram_addr = 7'h03;
    @(posedge clk); @(negedge clk);
    clr_stb = 1'b0; tst_stb = 1'b0;
    m_lat[3] = 1'b0;
    chk("R12", 32'(port_out), 32'(m_lat));
    chk("R12", 32'(skip_req), 32'd0);
    // R12: set and test together on nibble 10 -> flag 1 set, no skip
    set_stb = 1'b1; tst_stb = 1'b1; ram_addr = 7'h0A;
    @(posedge clk); @(negedge clk);
    set_stb = 1'b0; tst_stb = 1'b0;
    m_ff[1] = 1'b1;
    chk("R12", 32'(irq_ff), 32'(m_ff));
    chk("R12", 32'(skip_req), 32'd0);

    // Legacy instance: window on address bits 5:4, history of one cycle
    l_mask = '1; l_pins = '0;
    leg_cmd(1, 7'h05, 8'h00, 1'b0, 1'b0, "R10");
    leg_cmd(1, 7'h35, 8'h20, 1'b0, 1'b0, "R10");
    leg_cmd(1, 7'h06, 8'h60, 1'b0, 1'b0, "R10");
    leg_cmd(1, 7'h07, 8'h60, 1'b0, 1'b0, "R10");
    leg_cmd(1, 7'h3A, 8'h60, 1'b0, 1'b1, "R11");
    leg_cmd(1, 7'h72, 8'h64, 1'b0, 1'b0, "R11");
    leg_cmd(3, 7'h32, 8'h64, 1'b0, 1'b0, "R10");
    leg_cmd(3, 7'h33, 8'h64, 1'b1, 1'b0, "R10");
    leg_cmd(2, 7'h35, 8'h44, 1'b0, 1'b0, "R10");
    leg_cmd(3, 7'h03, 8'h44, 1'b1, 1'b0, "R10");
    leg_cmd(3, 7'h04, 8'h44, 1'b0, 1'b0, "R10");
    leg_cmd(3, 7'h3F, 8'h44, 1'b0, 1'b1, "R11");

    finish_run();
  end

endmodule